// File: doc/BRIEF.md
# Pipelined Parallel Dot-Product Accumulator

This block forms the signed integer dot product c = sum of a[i]*b[i] over a vector of N elements. The elements arrive as beats of 2^Z operand pairs, and each beat is qualified by `in_valid`. Every lane has its own multiplier, modelled as a fully pipelined unit with latency LM. A binary tree of adders, each with latency LA, merges the lane products. The merged value goes into a single accumulating adder, also of latency LA, whose output loops back to its own input. Because of that loop, consecutive merged values fall into LA interleaved partial sums used in turn. All partial sums start at zero.

When the stream has drained, the LA partial sums are captured and combined pairwise over log2(LA) adder levels, each of latency LA. A final stage of latency LA then brings the sum to the output register. At that moment `done` pulses for one cycle. The control is a four-state machine with these states:
- IDLE: waiting.
- STREAM: accepting beats.
- FLUSH: counting while the multiply, tree and accumulate pipelines drain.
- FOLD: waiting for the reduced sum.

The transitions are:
- go: IDLE to STREAM, on `start`.
- last-beat: STREAM to FLUSH, on the N/2^Z-th accepted beat.
- drained: FLUSH to FOLD, after a fixed count, in the cycle the partial sums are captured.
- folded: FOLD to IDLE, on `done`.

The parameters are the operand width DW, the lane exponent Z (0 to 4), LM (2 to 8), LA (2, 4 or 8) and N, which must be a multiple of 2^Z. For a full reduction the supported configurations are Z from 0 to 4, LM from 2 to 8 and LA of 2, 4 or 8.

Top module: `dotp_accum`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` seen while idle raises `busy` in the next cycle. `busy` stays high through the cycle in which `done` is high and is low in the cycle after it.
- R3: `result` equals the signed sum of a*b over the N elements of the run. Lane j of `a_vec`/`b_vec` occupies bits [j*DW +: DW] and carries element k*2^Z+j of beat k. Each run starts from zero.
- R4: `done` is high for exactly one cycle per run. `result` changes only in a cycle where `done` is high and otherwise holds its value.
- R5: With no idle cycles in the stream, count the cycle of the first accepted beat as 0. `done` is then high in cycle N/2^Z - 1 + LM + LA*(Z+1) + LA*(log2(LA)+1).
- R6: If `in_valid` is low in some cycles of the stream, `done` is high exactly LM + LA*(Z+1) + LA*(log2(LA)+1) cycles after the cycle of the last accepted beat.
- R7: A `start` given while `busy` is high has no effect on the result or on the timing of `done`.
- R8: Beats with `in_valid` high while idle, or after the N-th element of a run, are ignored and do not change the result of that run or the next.
- R9: Operands at the most negative value in every lane give the exact result N*2^(2*DW-2) without overflow. The result width is 2*DW+log2(N)+1 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| in_valid | input | 1 | Qualifies one beat of operand pairs |
| a_vec | input | 2^Z*DW | Packed signed a operands, lane j at [j*DW +: DW] |
| b_vec | input | 2^Z*DW | Packed signed b operands, lane j at [j*DW +: DW] |
| busy | output | 1 | High from the cycle after start through the done cycle |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 2*DW+log2(N)+1 | Signed dot product, held until the next done |

## Verification
The bench counts cycles from the cycle its first beat is presented. For a stream with no idle cycles it expects `done` exactly at the closed-form index of R5. For a stream with idle cycles it expects `done` at the cycle of the last beat plus the fixed tail of R6. Inputs change on the falling edge. Each output is read at the falling edge just before the change, so `done`, `result` and `busy` are seen in the exact cycle they are due, and `busy` again one cycle later. Three configurations with different Z, LM and LA check the latency formula across its terms.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_FLUSH,
        ST_FOLD
    } dp_state_e;
endpackage

// File: rtl/dp_pipe.sv
// Plain delay line modelling the latency of a fully pipelined unit (LAT >= 1)
module dp_pipe #(
    parameter int W   = 8,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAT-1];
endmodule

// File: rtl/dp_add_tree.sv
// Binary adder tree with K (power of two, >= 2) inputs; each level has latency LAT.
// A valid bit rides in the top bit of every level.
module dp_add_tree #(
    parameter int K   = 4,
    parameter int W   = 16,
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_v,
    input  logic [K*W-1:0] in_d,
    output logic           out_v,
    output logic [W-1:0]   out_d
);
    localparam int L = $clog2(K);

    for (genvar l = 0; l < L; l++) begin : g_lvl
        localparam int NI = K >> l;
        localparam int NO = NI / 2;
        logic [NI*W:0] din;
        logic [NO*W:0] sum;
        logic [NO*W:0] dout;

        if (l == 0) begin : g_first
            assign din = {in_v, in_d};
        end else begin : g_next
            assign din = g_lvl[l-1].dout;
        end

        for (genvar j = 0; j < NO; j++) begin : g_add
            assign sum[j*W +: W] = din[2*j*W +: W] + din[(2*j+1)*W +: W];
        end
        assign sum[NO*W] = din[NI*W];

        dp_pipe #(.W(NO*W+1), .LAT(LAT)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (sum),
            .q    (dout)
        );
    end

    assign out_v = g_lvl[L-1].dout[W];
    assign out_d = g_lvl[L-1].dout[W-1:0];
endmodule

// File: rtl/dp_ring_acc.sv
// Accumulating adder of latency D whose output feeds its own input:
// D partial sums circulate, each input lands in the slot now at the adder.
module dp_ring_acc #(
    parameter int W = 16,
    parameter int D = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           in_v,
    input  logic [W-1:0]   in_d,
    output logic [D*W-1:0] snap
);
    logic [W-1:0] slot [D];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) slot[i] <= '0;
        end else if (clear) begin
            for (int i = 0; i < D; i++) slot[i] <= '0;
        end else begin
            slot[0] <= (in_v ? in_d : '0) + slot[D-1];
            for (int i = 1; i < D; i++) slot[i] <= slot[i-1];
        end
    end

    for (genvar s = 0; s < D; s++) begin : g_snap
        assign snap[s*W +: W] = slot[s];
    end
endmodule

// File: rtl/dotp_ctrl.sv
// Run controller: go -> last-beat -> drained -> folded
module dotp_ctrl
    import dotp_pkg::*;
#(
    parameter int M          = 256,
    parameter int FLUSH_LAST = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    input  logic fin,
    output logic busy,
    output logic accept,
    output logic capture,
    output logic clear
);
    localparam int BW = $clog2(M) + 1;
    localparam int FW = $clog2(FLUSH_LAST + 1) + 1;

    dp_state_e     state_q, state_d;
    logic [BW-1:0] beat_q;
    logic [FW-1:0] flush_q;
    logic          last_beat, drained;

    assign last_beat = in_valid && (beat_q == BW'(M - 1));
    assign drained   = (flush_q == FW'(FLUSH_LAST));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions; R7: start only acts in ST_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_STREAM;
            ST_STREAM: if (last_beat) state_d = ST_FLUSH;
            ST_FLUSH:  if (drained)   state_d = ST_FOLD;
            ST_FOLD:   if (fin)       state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Beat and drain counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q  <= '0;
            flush_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    beat_q  <= '0;
                    flush_q <= '0;
                end
                ST_STREAM: if (in_valid) beat_q <= beat_q + 1'b1;
                ST_FLUSH:  flush_q <= flush_q + 1'b1;
                default: ;
            endcase
        end
    end

    // Outputs; R8: beats are taken only in ST_STREAM
    always_comb begin
        busy    = (state_q != ST_IDLE);
        accept  = (state_q == ST_STREAM) && in_valid;
        capture = (state_q == ST_FLUSH) && drained;
        clear   = (state_q == ST_IDLE) && start;
    end
endmodule

// File: rtl/dotp_accum.sv
module dotp_accum #(
    parameter int DW = 16,
    parameter int Z  = 2,
    parameter int LM = 3,
    parameter int LA = 4,
    parameter int N  = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       in_valid,
    input  logic [(1<<Z)*DW-1:0]       a_vec,
    input  logic [(1<<Z)*DW-1:0]       b_vec,
    output logic                       busy,
    output logic                       done,
    output logic [2*DW+$clog2(N):0]    result
);
    localparam int LANES      = 1 << Z;
    localparam int ACCW       = 2*DW + $clog2(N) + 1;   // R9 headroom
    localparam int M          = N / LANES;
    localparam int FLUSH_LAST = LM + (Z + 1)*LA - 1;    // R5/R6 drain count

    logic                  accept, capture, clear;
    logic [LANES*ACCW-1:0] prod_d;
    logic                  prod_v;
    logic                  tree_v;
    logic [ACCW-1:0]       tree_d;
    logic [LA*ACCW-1:0]    snap, red_in;
    logic                  red_v;
    logic [ACCW-1:0]       red_d;
    logic [ACCW:0]         tail_q;
    logic                  done_q;
    logic [ACCW-1:0]       result_q;

    dotp_ctrl #(.M(M), .FLUSH_LAST(FLUSH_LAST)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .in_valid(in_valid),
        .fin     (done_q),
        .busy    (busy),
        .accept  (accept),
        .capture (capture),
        .clear   (clear)
    );

    // Multiply lanes (R3): product zeroed when no beat is taken
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic signed [DW-1:0]   aj, bj;
        logic signed [2*DW-1:0] pj;
        logic [ACCW-1:0]        ext;
        assign aj  = a_vec[j*DW +: DW];
        assign bj  = b_vec[j*DW +: DW];
        assign pj  = aj * bj;
        assign ext = accept ? {{(ACCW-2*DW){pj[2*DW-1]}}, pj} : '0;
        dp_pipe #(.W(ACCW), .LAT(LM)) u_mul (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (ext),
            .q    (prod_d[j*ACCW +: ACCW])
        );
    end

    dp_pipe #(.W(1), .LAT(LM)) u_mulv (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (accept),
        .q    (prod_v)
    );

    // Lane merge tree: Z levels of latency LA
    if (Z == 0) begin : g_single
        assign tree_v = prod_v;
        assign tree_d = prod_d;
    end else begin : g_merge
        dp_add_tree #(.K(LANES), .W(ACCW), .LAT(LA)) u_tree (
            .clk  (clk),
            .rst_n(rst_n),
            .in_v (prod_v),
            .in_d (prod_d),
            .out_v(tree_v),
            .out_d(tree_d)
        );
    end

    dp_ring_acc #(.W(ACCW), .D(LA)) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear),
        .in_v (tree_v),
        .in_d (tree_d),
        .snap (snap)
    );

    // Fold the LA partial sums: log2(LA) levels, then one more LA stage
    assign red_in = capture ? snap : '0;

    dp_add_tree #(.K(LA), .W(ACCW), .LAT(LA)) u_fold (
        .clk  (clk),
        .rst_n(rst_n),
        .in_v (capture),
        .in_d (red_in),
        .out_v(red_v),
        .out_d(red_d)
    );

    dp_pipe #(.W(ACCW+1), .LAT(LA-1)) u_tail (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({red_v, red_d}),
        .q    (tail_q)
    );

    // Output register closes the last LA stage (R4: result held between runs)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= tail_q[ACCW];
            if (tail_q[ACCW]) result_q <= tail_q[ACCW-1:0];
        end
    end

    assign done   = done_q;
    assign result = result_q;
endmodule

// File: rtl/dotp_accum_chk.sv
module dotp_accum_chk #(
    parameter int W = 43
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result
);
    a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy)
        else $error("R2: busy not raised after start");

    a_r2_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy)
        else $error("R2: busy still high after done");

    a_r2_done_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("R2: done without busy");

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R4: done longer than one cycle");

    a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result))
        else $error("R4: result moved without done");

    a_r8_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !done)
        else $error("R8: done raised from idle");
endmodule

bind dotp_accum dotp_accum_chk #(.W(2*DW+$clog2(N)+1)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .result(result)
);

// File: tb/dotp_accum_bench.sv
module dotp_accum_harness #(
    parameter int          Z    = 2,
    parameter int          LM   = 3,
    parameter int          LA   = 4,
    parameter int          N    = 1024,
    parameter int unsigned SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_err,
    output logic fin
);
    localparam int DW    = 16;
    localparam int LANES = 1 << Z;
    localparam int M     = N / LANES;
    localparam int ACCW  = 2*DW + $clog2(N) + 1;
    localparam int LOGLA = $clog2(LA);
    localparam int TAIL  = LM + LA*(Z+1) + LA*(LOGLA+1);
    localparam int CEXP  = M - 1 + TAIL;
    localparam int WIN   = 3*M + TAIL + 20;

    logic                  start, in_valid;
    logic [LANES*DW-1:0]   a_vec, b_vec;
    logic                  busy, done;
    logic [ACCW-1:0]       result;

    logic signed [DW-1:0]  ea [N];
    logic signed [DW-1:0]  eb [N];
    int                    done_cyc, last_cyc, ndone;
    logic                  busy_at_done, busy_after;
    longint                res_at_done, res_late;

    dotp_accum #(.DW(DW), .Z(Z), .LM(LM), .LA(LA), .N(N)) u_dotp_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .in_valid(in_valid),
        .a_vec   (a_vec),
        .b_vec   (b_vec),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    function automatic longint sx(input logic [ACCW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint expect_dot();
        longint s = 0;
        for (int i = 0; i < N; i++) s += longint'(ea[i]) * longint'(eb[i]);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (Z=%0d LM=%0d LA=%0d): actual %0d expected %0d",
                     req, Z, LM, LA, act, exp);
        end
    endtask

    task automatic fill(input int mode);
        for (int i = 0; i < N; i++) begin
            case (mode)
                0: begin ea[i] = 16'sd1; eb[i] = 16'sd1; end
                1: begin ea[i] = 16'sh8000; eb[i] = 16'sh8000; end
                2: begin ea[i] = DW'($urandom); eb[i] = DW'($urandom); end
                default: begin
                    if (i % 7 == 0) begin
                        ea[i] = (i % 2 == 0) ? 16'sh7fff : 16'sh8000;
                        eb[i] = 16'sh8000;
                    end else begin
                        ea[i] = DW'($urandom);
                        eb[i] = DW'($urandom);
                    end
                end
            endcase
        end
    endtask

    task automatic run(input bit gaps, input bit mid_start, input bit extra);
        int beat;
        ndone = 0; done_cyc = -1; last_cyc = -1;
        busy_at_done = 1'b0; busy_after = 1'b1;
        @(negedge clk);
        start = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", longint'(busy), 1);
        beat = 0;
        for (int cyc = 0; cyc < WIN; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (done === 1'b1) begin
                ndone++;
                done_cyc     = cyc;
                busy_at_done = busy;
                res_at_done  = sx(result);
            end
            if (ndone > 0 && cyc == done_cyc + 1) busy_after = busy;
            start = mid_start && (cyc == M/2);
            if (beat < M && !(gaps && $urandom_range(2) == 0)) begin
                for (int j = 0; j < LANES; j++) begin
                    a_vec[j*DW +: DW] = ea[beat*LANES + j];
                    b_vec[j*DW +: DW] = eb[beat*LANES + j];
                end
                in_valid = 1'b1;
                last_cyc = cyc;
                beat++;
            end else begin
                in_valid = (beat >= M) ? extra : 1'b0;
                for (int j = 0; j < LANES; j++) begin
                    a_vec[j*DW +: DW] = DW'($urandom);
                    b_vec[j*DW +: DW] = DW'($urandom);
                end
            end
        end
        start = 1'b0; in_valid = 1'b0;
        res_late = sx(result);
    endtask

    task automatic post(input string tag, input bit gapped);
        longint e;
        e = expect_dot();
        chk(ndone == 1, "R4 one done pulse per run", ndone, 1);
        chk(res_at_done == e, tag, res_at_done, e);
        chk(res_late == res_at_done, "R4 result held after done", res_late, res_at_done);
        chk(busy_at_done == 1'b1 && busy_after == 1'b0, "R2 busy through done then low",
            {busy_at_done, busy_after}, 2);
        if (!gapped) chk(done_cyc == CEXP, "R5 closed-form cycle count", done_cyc, CEXP);
        chk(done_cyc == last_cyc + TAIL, "R6 done after last beat", done_cyc - last_cyc, TAIL);
    endtask

    initial begin
        start = 1'b0; in_valid = 1'b0; a_vec = '0; b_vec = '0;
        n_chk = 0; n_err = 0; fin = 1'b0;
        void'($urandom(SEED));
        wait (rst_n === 1'b1);
        @(negedge clk);
        // R1
        chk(busy === 1'b0 && done === 1'b0 && result === '0, "R1 reset state",
            sx(result), 0);
        // R8: beats while idle
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            a_vec = (LANES*DW)'({$urandom, $urandom, $urandom, $urandom, $urandom,
                                 $urandom, $urandom, $urandom});
            b_vec = ~a_vec;
            @(negedge clk);
            chk(busy === 1'b0 && done === 1'b0, "R8 idle beats ignored", longint'(busy), 0);
        end
        in_valid = 1'b0;
        fill(0); run(1'b0, 1'b0, 1'b0); post("R3 all-ones sum", 1'b0);
        fill(1); run(1'b0, 1'b0, 1'b0); post("R9 most-negative operands", 1'b0);
        fill(2); run(1'b0, 1'b0, 1'b1); post("R8 beats after the last ignored", 1'b0);
        fill(3); run(1'b1, 1'b0, 1'b0); post("R3 gapped stream sum (R6)", 1'b1);
        fill(2); run(1'b0, 1'b1, 1'b0); post("R7 start while busy ignored", 1'b0);
        fill(3); run(1'b1, 1'b1, 1'b1); post("R7 gapped with restart attempt", 1'b1);
        fin = 1'b1;
    end
endmodule

module dotp_accum_bench;
    logic clk, rst_n;
    int   c0, c1, c2, e0, e1, e2;
    logic f0, f1, f2;

    initial clk = 1'b0;
    always #2 clk = ~clk;

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    end

    dotp_accum_harness #(.Z(2), .LM(3), .LA(4), .N(1024), .SEED(11)) h_wide (
        .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_err(e0), .fin(f0));
    dotp_accum_harness #(.Z(0), .LM(2), .LA(2), .N(16), .SEED(23)) h_single (
        .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_err(e1), .fin(f1));
    dotp_accum_harness #(.Z(4), .LM(8), .LA(8), .N(128), .SEED(37)) h_deep (
        .clk(clk), .rst_n(rst_n), .n_chk(c2), .n_err(e2), .fin(f2));

    initial begin
        int cycles;
        int checks, errors;
        cycles = 0;
        while (!(f0 === 1'b1 && f1 === 1'b1 && f2 === 1'b1) && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        checks = c0 + c1 + c2;
        errors = e0 + e1 + e2;
        if (cycles >= 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule